// File: doc/BRIEF.md
# Performance Counter User-Access Gate

This block decides whether an access made at the least-privileged level (level 0) to a performance monitoring resource may proceed. It holds a four-bit user-access control value: one global enable and three per-resource overrides. Each override opens one class of resource to user code when the global enable is clear. The three classes are event-counter reads, cycle-counter reads and software-increment writes.

Each request carries these fields:
- the current privilege level;
- a resource-kind code;
- a write flag;
- the execution width (64-bit, or 32-bit with a single- or double-word transfer);
- two flags that say whether a hypervisor is present and whether traps are routed to it.

The request is captured in a register. One cycle later the gate gives exactly one verdict: allow, trap or undefined. When the verdict is trap, it also gives the level that takes the trap and the syndrome class to report. The control value is loaded through a plain load port, and its zero-extended 64-bit view can be read back.

Top module: `pmu_user_gate`

## Requirements
- R1: While reset is asserted and after reset, the control value is zero and allow, trap and undefined are all low.
- R2: A control load keeps data bits [3:0]. Bit 0 is the global enable, bit 1 the software-increment override, bit 2 the cycle-read override and bit 3 the event-read override. The 64-bit view reads zero in bits [63:4] whatever was written there.
- R3: A request sampled at a clock edge gives its verdict after that edge and before the next one. When valid was high, exactly one of allow, trap and undefined is high. When valid was low, none of them is high.
- R4: A request from any level other than 0 is allowed.
- R5: At level 0 with the global enable set, every request is allowed, including a software-increment read.
- R6: The kind codes are 0 (direct event counter), 1 (selected event counter) and 2 (counter select). With the global enable clear and the event-read override set: reads of kinds 0 and 1 are allowed, writes to them are trapped, and both reads and writes of kind 2 are allowed. With the override clear, all three kinds trap.
- R7: Kind 3 is the cycle counter. With the global enable clear, a read is allowed only when the cycle-read override is set. A write always traps.
- R8: Kind 4 is software increment. With the global enable clear, a write is allowed only when the software-increment override is set, and traps otherwise. A read is reported as undefined and never as a trap.
- R9: Kind 5 covers the interrupt-enable set and clear registers. It is always allowed, whatever the control value.
- R10: Kinds 6 and 7 are other monitor registers. They trap at level 0 whenever the global enable is clear.
- R11: A trap targets level 2 when both the hypervisor-present flag and the route flag are set. Otherwise it targets level 1.
- R12: The trap syndrome depends on width and transfer:
  - in 64-bit mode (narrow flag 0) it is 0x18;
  - in 32-bit mode a double-word cycle-counter transfer reports 0x04;
  - any other 32-bit trap reports 0x03.
- R13: When trap is low, the target level and the syndrome are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_load_i | input | 1 | Load the control value from ctl_data_i |
| ctl_data_i | input | REG_W | Control data; only bits [3:0] are kept |
| ctl_view_o | output | REG_W | Zero-extended view of the control value |
| req_valid_i | input | 1 | Request present |
| req_level_i | input | 2 | Privilege level of the requester |
| req_kind_i | input | 3 | Resource kind code (see R6 to R10) |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_narrow_i | input | 1 | 1 for 32-bit execution, 0 for 64-bit |
| req_dword_i | input | 1 | 32-bit double-word transfer |
| hyp_present_i | input | 1 | Hypervisor present and enabled |
| hyp_route_i | input | 1 | Route traps to the hypervisor |
| allow_o | output | 1 | Access may proceed |
| trap_o | output | 1 | Access is trapped |
| undef_o | output | 1 | Access is undefined |
| tgt_level_o | output | 2 | Level that takes the trap |
| syndrome_o | output | SYN_W | Syndrome class of the trap |

## Verification
The bench aims at the places where a per-resource override is easy to mis-wire:
- Event-counter writes must trap even when the event-read override is set. A gate that ignores the write flag would let them through.
- Counter-select writes must be allowed under that same override. A gate that applies the read-only rule to kind 2 as well would trap them.
- Software-increment reads must come out as undefined. A gate that treats them like writes would report a trap or an allow.

The bench also checks the syndrome split for 32-bit double-word transfers, which only the cycle counter may report as 0x04. It checks the routing to level 2, which needs both hypervisor flags, so a design that uses only one flag will pick the wrong target level. Random requests across every kind, level, width and control value then compare all five outputs at once.

// File: rtl/pmu_ua_pkg.sv
package pmu_ua_pkg;

   localparam int LVL_W  = 2;
   localparam int KIND_W = 3;
   localparam int CTL_W  = 4;

   typedef enum logic [KIND_W-1:0] {
      K_EVT_DIRECT   = 3'd0,
      K_EVT_INDIRECT = 3'd1,
      K_CNT_SELECT   = 3'd2,
      K_CYCLE        = 3'd3,
      K_SOFT_INC     = 3'd4,
      K_INT_ENABLE   = 3'd5,
      K_OTHER_A      = 3'd6,
      K_OTHER_B      = 3'd7
   } kind_e;

   // Packed field order gives bit 3 down to bit 0.
   typedef struct packed {
      logic evt_rd;
      logic cyc_rd;
      logic inc_wr;
      logic glb;
   } ctl_t;

   typedef struct packed {
      logic             valid;
      logic [LVL_W-1:0] level;
      kind_e            kind;
      logic             write;
      logic             narrow;
      logic             dword;
      logic             hyp_on;
      logic             hyp_route;
   } req_t;

   typedef enum logic [1:0] {
      V_NONE  = 2'd0,
      V_ALLOW = 2'd1,
      V_TRAP  = 2'd2,
      V_UNDEF = 2'd3
   } verdict_e;

endpackage

// File: rtl/ua_ctl_reg.sv
module ua_ctl_reg
   import pmu_ua_pkg::*;
#(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [REG_W-1:0] data_i,
   output ctl_t             ctl_o,
   output logic [REG_W-1:0] view_o
);

   localparam int PAD_W = REG_W - CTL_W;

   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (load_i) begin
         ctl_q <= ctl_t'(data_i[CTL_W-1:0]);
      end
   end

   assign ctl_o = ctl_q;

   generate
      if (PAD_W > 0) begin : g_pad
         assign view_o = {{PAD_W{1'b0}}, ctl_q};
      end else begin : g_nopad
         assign view_o = ctl_q;
      end
   endgenerate

endmodule

// File: rtl/ua_req_stage.sv
module ua_req_stage
   import pmu_ua_pkg::*;
#(
   parameter bit IN_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  req_t req_i,
   output req_t req_o
);

   generate
      if (IN_REG) begin : g_reg
         req_t req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= '0;
            end else begin
               req_q <= req_i;
            end
         end
         assign req_o = req_q;
      end else begin : g_wire
         assign req_o = req_i;
      end
   endgenerate

endmodule

// File: rtl/ua_verdict.sv
module ua_verdict
   import pmu_ua_pkg::*;
#(
   parameter int USER_LVL = 0
) (
   input  req_t     req_i,
   input  ctl_t     ctl_i,
   output verdict_e verdict_o
);

   localparam logic [LVL_W-1:0] USER_L = LVL_W'(USER_LVL);

   logic privileged;
   logic open_all;

   assign privileged = (req_i.level != USER_L);
   assign open_all   = privileged || ctl_i.glb || (req_i.kind == K_INT_ENABLE);

   always_comb begin
      verdict_o = V_NONE;
      if (req_i.valid) begin
         if (open_all) begin
            verdict_o = V_ALLOW;
         end else begin
            case (req_i.kind)
               K_EVT_DIRECT, K_EVT_INDIRECT:
                  verdict_o = (ctl_i.evt_rd && !req_i.write) ? V_ALLOW : V_TRAP;
               K_CNT_SELECT:
                  verdict_o = ctl_i.evt_rd ? V_ALLOW : V_TRAP;
               K_CYCLE:
                  verdict_o = (ctl_i.cyc_rd && !req_i.write) ? V_ALLOW : V_TRAP;
               K_SOFT_INC: begin
                  if (!req_i.write) begin
                     verdict_o = V_UNDEF;
                  end else begin
                     verdict_o = ctl_i.inc_wr ? V_ALLOW : V_TRAP;
                  end
               end
               default:
                  verdict_o = V_TRAP;
            endcase
         end
      end
   end

endmodule

// File: rtl/ua_route.sv
module ua_route
   import pmu_ua_pkg::*;
#(
   parameter int SYN_W         = 6,
   parameter int TGT_BASE      = 1,
   parameter int TGT_HYP       = 2,
   parameter int SYN_WIDE      = 'h18,
   parameter int SYN_NARROW    = 'h03,
   parameter int SYN_NARROW_DW = 'h04
) (
   input  req_t             req_i,
   input  verdict_e         verdict_i,
   output logic [LVL_W-1:0] tgt_o,
   output logic [SYN_W-1:0] syn_o
);

   localparam logic [LVL_W-1:0] TGT_B = LVL_W'(TGT_BASE);
   localparam logic [LVL_W-1:0] TGT_H = LVL_W'(TGT_HYP);
   localparam logic [SYN_W-1:0] S_W   = SYN_W'(SYN_WIDE);
   localparam logic [SYN_W-1:0] S_N   = SYN_W'(SYN_NARROW);
   localparam logic [SYN_W-1:0] S_ND  = SYN_W'(SYN_NARROW_DW);

   logic is_trap;
   logic to_hyp;
   logic pair_xfer;

   assign is_trap   = (verdict_i == V_TRAP);
   assign to_hyp    = req_i.hyp_on && req_i.hyp_route;
   assign pair_xfer = req_i.dword && (req_i.kind == K_CYCLE);

   always_comb begin
      tgt_o = '0;
      syn_o = '0;
      if (is_trap) begin
         tgt_o = to_hyp ? TGT_H : TGT_B;
         if (!req_i.narrow) begin
            syn_o = S_W;
         end else begin
            syn_o = pair_xfer ? S_ND : S_N;
         end
      end
   end

endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
   import pmu_ua_pkg::*;
#(
   parameter int REG_W         = 64,
   parameter int SYN_W         = 6,
   parameter int USER_LVL      = 0,
   parameter int TGT_BASE      = 1,
   parameter int TGT_HYP       = 2,
   parameter int SYN_WIDE      = 'h18,
   parameter int SYN_NARROW    = 'h03,
   parameter int SYN_NARROW_DW = 'h04,
   parameter bit IN_REG        = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_load_i,
   input  logic [REG_W-1:0] ctl_data_i,
   output logic [REG_W-1:0] ctl_view_o,
   input  logic             req_valid_i,
   input  logic [1:0]       req_level_i,
   input  logic [2:0]       req_kind_i,
   input  logic             req_write_i,
   input  logic             req_narrow_i,
   input  logic             req_dword_i,
   input  logic             hyp_present_i,
   input  logic             hyp_route_i,
   output logic             allow_o,
   output logic             trap_o,
   output logic             undef_o,
   output logic [1:0]       tgt_level_o,
   output logic [SYN_W-1:0] syndrome_o
);

   localparam int SYN_MAX = 1 << SYN_W;
   localparam int LVL_MAX = 1 << LVL_W;

   generate
      if (REG_W < CTL_W) begin : g_bad_reg_w
         $error("REG_W must hold the four control bits");
      end
      if (SYN_WIDE >= SYN_MAX || SYN_NARROW >= SYN_MAX || SYN_NARROW_DW >= SYN_MAX) begin : g_bad_syn
         $error("a syndrome code does not fit in SYN_W bits");
      end
      if (USER_LVL >= LVL_MAX || TGT_BASE >= LVL_MAX || TGT_HYP >= LVL_MAX) begin : g_bad_lvl
         $error("a level value does not fit in the level field");
      end
   endgenerate

   ctl_t     ctl;
   req_t     req_in;
   req_t     req_cur;
   verdict_e verdict;

   always_comb begin
      req_in           = '0;
      req_in.valid     = req_valid_i;
      req_in.level     = req_level_i;
      req_in.kind      = kind_e'(req_kind_i);
      req_in.write     = req_write_i;
      req_in.narrow    = req_narrow_i;
      req_in.dword     = req_dword_i;
      req_in.hyp_on    = hyp_present_i;
      req_in.hyp_route = hyp_route_i;
   end

   ua_ctl_reg #(.REG_W(REG_W)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ctl_load_i),
      .data_i (ctl_data_i),
      .ctl_o  (ctl),
      .view_o (ctl_view_o)
   );

   ua_req_stage #(.IN_REG(IN_REG)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_in),
      .req_o (req_cur)
   );

   ua_verdict #(.USER_LVL(USER_LVL)) u_verdict (
      .req_i     (req_cur),
      .ctl_i     (ctl),
      .verdict_o (verdict)
   );

   ua_route #(
      .SYN_W         (SYN_W),
      .TGT_BASE      (TGT_BASE),
      .TGT_HYP       (TGT_HYP),
      .SYN_WIDE      (SYN_WIDE),
      .SYN_NARROW    (SYN_NARROW),
      .SYN_NARROW_DW (SYN_NARROW_DW)
   ) u_route (
      .req_i     (req_cur),
      .verdict_i (verdict),
      .tgt_o     (tgt_level_o),
      .syn_o     (syndrome_o)
   );

   assign allow_o = (verdict == V_ALLOW);
   assign trap_o  = (verdict == V_TRAP);
   assign undef_o = (verdict == V_UNDEF);

endmodule

// File: rtl/pmu_user_gate_chk.sv
module pmu_user_gate_chk #(
   parameter int REG_W    = 64,
   parameter int SYN_W    = 6,
   parameter int TGT_BASE = 1,
   parameter int TGT_HYP  = 2,
   parameter int SYN_WIDE = 'h18,
   parameter bit IN_REG   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] ctl_view_o,
   input logic             req_valid_i,
   input logic [1:0]       req_level_i,
   input logic [2:0]       req_kind_i,
   input logic             req_write_i,
   input logic             req_narrow_i,
   input logic             hyp_present_i,
   input logic             hyp_route_i,
   input logic             allow_o,
   input logic             trap_o,
   input logic             undef_o,
   input logic [1:0]       tgt_level_o,
   input logic [SYN_W-1:0] syndrome_o
);

   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else begin
         arm_q <= 1'b1;
      end
   end

   p_quiet_no_trap_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> (tgt_level_o == 2'd0 && syndrome_o == '0));

   generate
      if (IN_REG) begin : g_timed
         p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && $past(req_valid_i)) |-> $onehot({allow_o, trap_o, undef_o}));

         p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && !$past(req_valid_i)) |-> !(allow_o || trap_o || undef_o));

         p_upper_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && $past(req_valid_i) && $past(req_level_i) != 2'd0) |-> allow_o);

         p_global_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && $past(req_valid_i) && ctl_view_o[0]) |-> allow_o);

         p_undef_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && undef_o) |-> ($past(req_kind_i) == 3'd4 && !$past(req_write_i)));

         p_int_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && $past(req_valid_i) && $past(req_kind_i) == 3'd5) |-> allow_o);

         p_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && trap_o) |->
               (tgt_level_o == (($past(hyp_present_i) && $past(hyp_route_i)) ? 2'(TGT_HYP) : 2'(TGT_BASE))));

         p_wide_syn_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_q && trap_o && !$past(req_narrow_i)) |-> (syndrome_o == SYN_W'(SYN_WIDE)));
      end
   endgenerate

endmodule

bind pmu_user_gate pmu_user_gate_chk #(
   .REG_W    (REG_W),
   .SYN_W    (SYN_W),
   .TGT_BASE (TGT_BASE),
   .TGT_HYP  (TGT_HYP),
   .SYN_WIDE (SYN_WIDE),
   .IN_REG   (IN_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_view_o    (ctl_view_o),
   .req_valid_i   (req_valid_i),
   .req_level_i   (req_level_i),
   .req_kind_i    (req_kind_i),
   .req_write_i   (req_write_i),
   .req_narrow_i  (req_narrow_i),
   .hyp_present_i (hyp_present_i),
   .hyp_route_i   (hyp_route_i),
   .allow_o       (allow_o),
   .trap_o        (trap_o),
   .undef_o       (undef_o),
   .tgt_level_o   (tgt_level_o),
   .syndrome_o    (syndrome_o)
);

// File: tb/tb_pmu_user_gate.sv
module tb_pmu_user_gate;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ctl_load_i;
   logic [63:0] ctl_data_i;
   logic [63:0] ctl_view_o;
   logic        req_valid_i;
   logic [1:0]  req_level_i;
   logic [2:0]  req_kind_i;
   logic        req_write_i;
   logic        req_narrow_i;
   logic        req_dword_i;
   logic        hyp_present_i;
   logic        hyp_route_i;
   logic        allow_o;
   logic        trap_o;
   logic        undef_o;
   logic [1:0]  tgt_level_o;
   logic [5:0]  syndrome_o;

   int   checks   = 0;
   int   failures = 0;
   logic [3:0] ctl_model = 4'd0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmu_user_gate dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_load_i    (ctl_load_i),
      .ctl_data_i    (ctl_data_i),
      .ctl_view_o    (ctl_view_o),
      .req_valid_i   (req_valid_i),
      .req_level_i   (req_level_i),
      .req_kind_i    (req_kind_i),
      .req_write_i   (req_write_i),
      .req_narrow_i  (req_narrow_i),
      .req_dword_i   (req_dword_i),
      .hyp_present_i (hyp_present_i),
      .hyp_route_i   (hyp_route_i),
      .allow_o       (allow_o),
      .trap_o        (trap_o),
      .undef_o       (undef_o),
      .tgt_level_o   (tgt_level_o),
      .syndrome_o    (syndrome_o)
   );

   // Expected {allow, trap, undef, target[1:0], syndrome[5:0]} from the requirements.
   function automatic logic [10:0] model(input logic [3:0] c, input logic v,
                                         input logic [1:0] lv, input logic [2:0] kd,
                                         input logic wr, input logic nr, input logic dw,
                                         input logic hp, input logic hr);
      logic a, t, u;
      logic [1:0] tg;
      logic [5:0] sy;
      a = 1'b0; t = 1'b0; u = 1'b0; tg = 2'd0; sy = 6'd0;
      if (v) begin
         if (lv != 2'd0 || c[0] || kd == 3'd5) begin
            a = 1'b1;
         end else begin
            case (kd)
               3'd0, 3'd1: if (c[3] && !wr) a = 1'b1; else t = 1'b1;
               3'd2:       if (c[3]) a = 1'b1; else t = 1'b1;
               3'd3:       if (c[2] && !wr) a = 1'b1; else t = 1'b1;
               3'd4:       if (!wr) u = 1'b1; else if (c[1]) a = 1'b1; else t = 1'b1;
               default:    t = 1'b1;
            endcase
         end
         if (t) begin
            tg = (hp && hr) ? 2'd2 : 2'd1;
            sy = !nr ? 6'h18 : ((dw && kd == 3'd3) ? 6'h04 : 6'h03);
         end
      end
      return {a, t, u, tg, sy};
   endfunction

   function automatic string tag_of(input logic [3:0] c, input logic [1:0] lv, input logic [2:0] kd);
      if (lv != 2'd0)   return "R4";
      if (c[0])         return "R5";
      if (kd == 3'd5)   return "R9";
      if (kd <= 3'd2)   return "R6";
      if (kd == 3'd3)   return "R7";
      if (kd == 3'd4)   return "R8";
      return "R10";
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic set_ctl(input logic [63:0] d);
      req_valid_i = 1'b0;
      ctl_load_i  = 1'b1;
      ctl_data_i  = d;
      @(negedge clk);
      ctl_load_i  = 1'b0;
      ctl_model   = d[3:0];
   endtask

   task automatic run_req(input string tag, input logic [1:0] lv, input logic [2:0] kd,
                          input logic wr, input logic nr, input logic dw,
                          input logic hp, input logic hr);
      req_valid_i   = 1'b1;
      req_level_i   = lv;
      req_kind_i    = kd;
      req_write_i   = wr;
      req_narrow_i  = nr;
      req_dword_i   = dw;
      hyp_present_i = hp;
      hyp_route_i   = hr;
      @(negedge clk);
      check(tag, 64'({allow_o, trap_o, undef_o, tgt_level_o, syndrome_o}),
            64'(model(ctl_model, 1'b1, lv, kd, wr, nr, dw, hp, hr)));
      req_valid_i   = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      ctl_load_i = 1'b0; ctl_data_i = '0;
      req_valid_i = 1'b0; req_level_i = '0; req_kind_i = '0; req_write_i = 1'b0;
      req_narrow_i = 1'b0; req_dword_i = 1'b0; hyp_present_i = 1'b0; hyp_route_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1: state while in reset
      check("R1", ctl_view_o, 64'd0);
      check("R1", 64'({allow_o, trap_o, undef_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 64'({allow_o, trap_o, undef_o}), 64'd0);

      // R2: only the low four bits are kept
      set_ctl(64'hFFFF_FFFF_FFFF_FFF5);
      check("R2", ctl_view_o, 64'h5);
      set_ctl(64'h0000_0000_0000_0000);
      check("R2", ctl_view_o, 64'h0);

      run_req("R4", 2'd1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R4", 2'd3, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      run_req("R6", 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      set_ctl(64'h8);
      run_req("R6", 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R6", 2'd0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      run_req("R6", 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R6", 2'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R7", 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      set_ctl(64'h4);
      run_req("R7", 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R7", 2'd0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R6", 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      set_ctl(64'h2);
      run_req("R8", 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R8", 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      set_ctl(64'h0);
      run_req("R8", 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R9", 2'd0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R9", 2'd0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      run_req("R10", 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R10", 2'd0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R11", 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      run_req("R11", 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_req("R11", 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      run_req("R12", 2'd0, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      run_req("R12", 2'd0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      run_req("R12", 2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      run_req("R12", 2'd0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      run_req("R13", 2'd2, 3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

      set_ctl(64'h1);
      run_req("R5", 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      run_req("R5", 2'd0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

      // R3: idle request gives no verdict
      req_valid_i = 1'b0; req_kind_i = 3'd6; req_level_i = 2'd0;
      @(negedge clk);
      check("R3", 64'({allow_o, trap_o, undef_o, tgt_level_o, syndrome_o}), 64'd0);

      for (int i = 0; i < 600; i++) begin
         if (i % 20 == 0) set_ctl({$urandom(), $urandom()});
         if ($urandom_range(0, 7) == 0) begin
            req_valid_i = 1'b0;
            req_level_i = 2'($urandom());
            req_kind_i  = 3'($urandom());
            @(negedge clk);
            check("R3", 64'({allow_o, trap_o, undef_o, tgt_level_o, syndrome_o}), 64'd0);
         end else begin
            logic [1:0] lv;
            logic [2:0] kd;
            lv = ($urandom_range(0, 3) == 0) ? 2'($urandom()) : 2'd0;
            kd = 3'($urandom());
            run_req(tag_of(ctl_model, lv, kd), lv, kd, 1'($urandom()), 1'($urandom()),
                    1'($urandom()), 1'($urandom()), 1'($urandom()));
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule